// File: doc/BRIEF.md
# Looping Envelope Shape Controller

This block sits beside an FM operator's envelope generator and adds looped envelope shapes to it. A 4-bit shape code chooses among repeat, hold, alternate and invert behaviour. On every envelope tick the block looks at the operator's envelope phase and attenuation. When a live envelope has decayed to half of full scale or beyond, the block does one of three things: it restarts the envelope, it parks it, or it flips its polarity. It also clamps a releasing envelope that reaches half scale straight to silence.

The controller never holds the attenuation itself. It sends write commands for the envelope phase and the attenuation, a one-cycle request to zero the operator's phase accumulator, and a one-cycle strobe whenever a shape event fires. It also turns the envelope core's normal attenuation step into the faster, gated step used by looped shapes. Finally it produces the attenuation seen by the operator, mirrored about half scale while inversion is in effect and before total level is added.

All outputs are registered. A command that follows from the inputs of one clock cycle appears one cycle later. Envelope phases are coded off=0, release=1, sustain=2, decay=3, attack=4, and "live" means a code above release. The shape code bits are: bit 3 enable, bit 2 invert, bit 1 alternate, bit 0 hold.

Top module: `ssg_env_ctrl`

## Requirements
- R1: While shape bit 3 is 0, no phase, attenuation, phase-reset or event output is asserted, the step output equals the step input, and the output attenuation equals the input attenuation. The internal polarity flag clears.
- R2: A shape event fires only in a cycle with `tick` high, shape bit 3 set, phase code above 1, and attenuation at least 512. Its results appear on the outputs one cycle later.
- R3: On an event with hold (bit 0) and alternate (bit 1) both set, the polarity flag becomes 1. A later event with the same code leaves it at 1, so the effective inversion (bit 2 XOR flag) flips only once.
- R4: On an event with hold set, if the effective inversion after the event is 0 and the phase is not attack, the attenuation is written to 1023. No phase write occurs.
- R5: On an event with hold clear and alternate set, the polarity flag toggles, so the effective inversion alternates from event to event.
- R6: On an event with hold and alternate both clear, `phase_clr` pulses for one cycle.
- R7: On an event with hold clear in a non-attack phase, the phase is written. If the rate input is at least 94, the attenuation is written to 0 and the phase becomes sustain (code 2) when the sustain level is 0, or decay (code 3) otherwise. If the rate input is below 94, the phase becomes attack (code 4). An event in attack writes neither.
- R8: With bit 3 set and the phase not attack, `step_out` is 4 times `step_in` when the attenuation is below 512, and 0 when it is at or above 512. In attack, or with bit 3 clear, `step_out` equals `step_in`.
- R9: On a tick with bit 3 set, phase release and attenuation at least 512, the attenuation is written to 1023 and the phase to off (code 0). `shape_evt` stays low.
- R10: When bit 3 is set, the effective inversion is 1 and the phase is live, `att_eff` is (512 − attenuation) mod 1024. Otherwise it equals the attenuation.
- R11: `shape_evt` pulses for exactly the cycles in which a shape event's results are presented.
- R12: During reset, every output is 0 and the polarity flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Envelope update strobe |
| shape | input | 4 | Shape code: bit3 enable, bit2 invert, bit1 alternate, bit0 hold |
| eg_phase | input | 3 | Current envelope phase code |
| eg_att | input | 10 | Current attenuation, 0 = loudest |
| sus_lvl | input | 10 | Sustain level attenuation |
| rate_ks | input | 7 | Attack rate plus key-scale contribution |
| step_in | input | 4 | Normal attenuation increment from the envelope core |
| phase_clr | output | 1 | Request to zero the operator phase |
| phase_we | output | 1 | Envelope phase write strobe |
| phase_wd | output | 3 | Envelope phase to write |
| att_we | output | 1 | Attenuation write strobe |
| att_wd | output | 10 | Attenuation to write |
| shape_evt | output | 1 | A shape event fired |
| step_out | output | 6 | Adjusted attenuation increment |
| att_eff | output | 10 | Attenuation presented to the operator |

## Verification
The only hidden state is the polarity flag, and a wrong flag shows in two places. It shows on `att_eff` in the cycle after any live sample, as a mirrored or unmirrored value. It also shows on the attenuation write that follows the next hold event. A bad threshold or phase comparison shows one cycle after the offending tick, as a missing or spurious write, phase-clear or event strobe. A bad step gate shows on `step_out` one cycle after the attenuation crosses 512. The reference model tracks the flag by itself and compares every output on every cycle. Any divergence is therefore reported within one cycle of the first cycle in which it can be seen.

// File: rtl/ssg_env_pkg.sv
package ssg_env_pkg;
  typedef enum logic [2:0] {
    ENV_OFF = 3'd0,
    ENV_REL = 3'd1,
    ENV_SUS = 3'd2,
    ENV_DEC = 3'd3,
    ENV_ATT = 3'd4
  } env_phase_t;

  localparam int SHAPE_HOLD = 0;
  localparam int SHAPE_ALT  = 1;
  localparam int SHAPE_INV  = 2;
  localparam int SHAPE_EN   = 3;
endpackage

// File: rtl/ssg_shape_event.sv
module ssg_shape_event
  import ssg_env_pkg::*;
#(
  parameter int ATT_W     = 10,
  parameter int RATE_W    = 7,
  parameter int FAST_RATE = 94
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [3:0]       shape,
  input  logic [2:0]       eg_phase,
  input  logic [ATT_W-1:0] eg_att,
  input  logic [ATT_W-1:0] sus_lvl,
  input  logic [RATE_W-1:0] rate_ks,
  output logic             phase_clr,
  output logic             phase_we,
  output logic [2:0]       phase_wd,
  output logic             att_we,
  output logic [ATT_W-1:0] att_wd,
  output logic             shape_evt,
  output logic             inv_now
);
  localparam logic [ATT_W-1:0]  HALF  = ATT_W'(1) << (ATT_W - 1);
  localparam logic [ATT_W-1:0]  FULL  = '1;
  localparam logic [RATE_W-1:0] FASTR = RATE_W'(FAST_RATE);

  logic       flip_q, flip_d;
  logic       clr_d, pwe_d, awe_d, hit_ssg, hit_rel, en, above;
  logic [2:0] pwd_d;
  logic [ATT_W-1:0] awd_d;
  env_phase_t cur;

  assign cur     = env_phase_t'(eg_phase);
  assign en      = shape[SHAPE_EN];
  assign above   = (eg_att >= HALF);
  assign hit_ssg = tick && en && above && (cur > ENV_REL);
  assign hit_rel = tick && en && above && (cur == ENV_REL);
  assign inv_now = shape[SHAPE_INV] ^ flip_q;

  always_comb begin
    flip_d = flip_q;
    clr_d  = 1'b0;
    pwe_d  = 1'b0;
    pwd_d  = 3'(ENV_OFF);
    awe_d  = 1'b0;
    awd_d  = '0;
    if (!en) begin
      flip_d = 1'b0;
    end else if (hit_ssg) begin
      if (shape[SHAPE_HOLD]) begin
        if (shape[SHAPE_ALT]) flip_d = 1'b1;
        if (!(shape[SHAPE_INV] ^ flip_d) && (cur != ENV_ATT)) begin
          awe_d = 1'b1;
          awd_d = FULL;
        end
      end else begin
        if (shape[SHAPE_ALT]) flip_d = ~flip_q;
        else                  clr_d  = 1'b1;
        if (cur != ENV_ATT) begin
          pwe_d = 1'b1;
          pwd_d = (sus_lvl == '0) ? 3'(ENV_SUS) : 3'(ENV_DEC);
          if (rate_ks >= FASTR) begin
            awe_d = 1'b1;
            awd_d = '0;
          end else if (eg_att != '0) begin
            pwd_d = 3'(ENV_ATT);
          end
        end
      end
    end else if (hit_rel) begin
      awe_d = 1'b1;
      awd_d = FULL;
      pwe_d = 1'b1;
      pwd_d = 3'(ENV_OFF);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flip_q    <= 1'b0;
      phase_clr <= 1'b0;
      phase_we  <= 1'b0;
      phase_wd  <= '0;
      att_we    <= 1'b0;
      att_wd    <= '0;
      shape_evt <= 1'b0;
    end else begin
      flip_q    <= flip_d;
      phase_clr <= clr_d;
      phase_we  <= pwe_d;
      phase_wd  <= pwd_d;
      att_we    <= awe_d;
      att_wd    <= awd_d;
      shape_evt <= hit_ssg;
    end
  end

  // R2: a phase-clear request always follows an enabled tick
  a_r2_clr_after_tick: assert property (@(posedge clk) disable iff (rst)
    phase_clr |-> ($past(tick) && $past(shape[SHAPE_EN])));

  // R1: nothing is commanded when the previous cycle was disabled
  a_r1_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(shape[SHAPE_EN]) |-> !(phase_clr || phase_we || att_we || shape_evt));

  // R4: attenuation writes are only ever full scale or zero
  a_r4_att_values: assert property (@(posedge clk) disable iff (rst)
    att_we |-> (att_wd == FULL || att_wd == '0));

  // R7: phase writes never name release
  a_r7_phase_legal: assert property (@(posedge clk) disable iff (rst)
    phase_we |-> (phase_wd != 3'(ENV_REL)));

  // R9: writing the off phase is never part of a shape event
  a_r9_off_not_event: assert property (@(posedge clk) disable iff (rst)
    (phase_we && phase_wd == 3'(ENV_OFF)) |-> !shape_evt);
endmodule

// File: rtl/ssg_step_gate.sv
module ssg_step_gate
  import ssg_env_pkg::*;
#(
  parameter int ATT_W  = 10,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        eg_phase,
  input  logic [ATT_W-1:0]  eg_att,
  input  logic [STEP_W-1:0] step_in,
  output logic [STEP_W+1:0] step_out
);
  localparam logic [ATT_W-1:0] HALF = ATT_W'(1) << (ATT_W - 1);

  logic [STEP_W+1:0] step_d;

  always_comb begin
    if (en && (env_phase_t'(eg_phase) != ENV_ATT)) begin
      step_d = (eg_att < HALF) ? {step_in, 2'b00} : '0;
    end else begin
      step_d = {2'b00, step_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_out <= '0;
    else     step_out <= step_d;
  end

  // R8: the adjusted step never exceeds four times the input step
  a_r8_step_bound: assert property (@(posedge clk) disable iff (rst)
    step_out <= {$past(step_in), 2'b00});
endmodule

// File: rtl/ssg_att_mirror.sv
module ssg_att_mirror
  import ssg_env_pkg::*;
#(
  parameter int ATT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             inv_now,
  input  logic [2:0]       eg_phase,
  input  logic [ATT_W-1:0] eg_att,
  output logic [ATT_W-1:0] att_eff
);
  localparam logic [ATT_W-1:0] HALF = ATT_W'(1) << (ATT_W - 1);

  logic             mirror;
  logic [ATT_W-1:0] eff_d;

  assign mirror = en && inv_now && (env_phase_t'(eg_phase) > ENV_REL);
  assign eff_d  = mirror ? (HALF - eg_att) : eg_att;

  always_ff @(posedge clk) begin
    if (rst) att_eff <= '0;
    else     att_eff <= eff_d;
  end

  // R10: outside live phases the attenuation passes through untouched
  a_r10_pass_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(eg_phase) <= 3'(ENV_REL)) |-> (att_eff == $past(eg_att)));
endmodule

// File: rtl/ssg_env_ctrl.sv
module ssg_env_ctrl
  import ssg_env_pkg::*;
#(
  parameter int ATT_W     = 10,
  parameter int RATE_W    = 7,
  parameter int STEP_W    = 4,
  parameter int FAST_RATE = 94
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [3:0]        shape,
  input  logic [2:0]        eg_phase,
  input  logic [ATT_W-1:0]  eg_att,
  input  logic [ATT_W-1:0]  sus_lvl,
  input  logic [RATE_W-1:0] rate_ks,
  input  logic [STEP_W-1:0] step_in,
  output logic              phase_clr,
  output logic              phase_we,
  output logic [2:0]        phase_wd,
  output logic              att_we,
  output logic [ATT_W-1:0]  att_wd,
  output logic              shape_evt,
  output logic [STEP_W+1:0] step_out,
  output logic [ATT_W-1:0]  att_eff
);
  logic inv_now;

  ssg_shape_event #(
    .ATT_W(ATT_W), .RATE_W(RATE_W), .FAST_RATE(FAST_RATE)
  ) u_event (
    .clk(clk), .rst(rst), .tick(tick), .shape(shape),
    .eg_phase(eg_phase), .eg_att(eg_att), .sus_lvl(sus_lvl), .rate_ks(rate_ks),
    .phase_clr(phase_clr), .phase_we(phase_we), .phase_wd(phase_wd),
    .att_we(att_we), .att_wd(att_wd), .shape_evt(shape_evt), .inv_now(inv_now)
  );

  ssg_step_gate #(
    .ATT_W(ATT_W), .STEP_W(STEP_W)
  ) u_step (
    .clk(clk), .rst(rst), .en(shape[SHAPE_EN]), .eg_phase(eg_phase),
    .eg_att(eg_att), .step_in(step_in), .step_out(step_out)
  );

  ssg_att_mirror #(
    .ATT_W(ATT_W)
  ) u_mirror (
    .clk(clk), .rst(rst), .en(shape[SHAPE_EN]), .inv_now(inv_now),
    .eg_phase(eg_phase), .eg_att(eg_att), .att_eff(att_eff)
  );

  // R11: an event strobe always comes with a command or a phase clear,
  // unless the event found the envelope in attack or holding inverted
  a_r11_evt_has_effect: assert property (@(posedge clk) disable iff (rst)
    (shape_evt && $past(eg_phase) != 3'(ENV_ATT) && !$past(shape[SHAPE_HOLD]))
      |-> phase_we);
endmodule

// File: tb/test_ssg_env_ctrl.sv
module test_ssg_env_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] shape = '0;
  logic [2:0] eg_phase = '0;
  logic [9:0] eg_att = '0;
  logic [9:0] sus_lvl = '0;
  logic [6:0] rate_ks = '0;
  logic [3:0] step_in = '0;
  logic       phase_clr, phase_we, att_we, shape_evt;
  logic [2:0] phase_wd;
  logic [9:0] att_wd, att_eff;
  logic [5:0] step_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string scen = "RESET";

  // reference state and expectations
  int pol = 0;
  int x_clr, x_pwe, x_pwd, x_awe, x_awd, x_evt, x_step, x_eff;
  bit have_x = 0;

  always #5 clk = ~clk;

  ssg_env_ctrl i_ssg_env_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .shape(shape), .eg_phase(eg_phase),
    .eg_att(eg_att), .sus_lvl(sus_lvl), .rate_ks(rate_ks), .step_in(step_in),
    .phase_clr(phase_clr), .phase_we(phase_we), .phase_wd(phase_wd),
    .att_we(att_we), .att_wd(att_wd), .shape_evt(shape_evt),
    .step_out(step_out), .att_eff(att_eff)
  );

  task automatic chk(string fld, string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s [%s] %s got=%0d exp=%0d at %0t", req, scen, fld, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk("phase_clr", "R6", phase_clr, x_clr);
    chk("phase_we",  "R7", phase_we,  x_pwe);
    if (x_pwe != 0) chk("phase_wd", "R7", phase_wd, x_pwd);
    chk("att_we",    "R4", att_we,    x_awe);
    if (x_awe != 0) chk("att_wd", "R4", att_wd, x_awd);
    chk("shape_evt", "R11", shape_evt, x_evt);
    chk("step_out",  "R8", step_out,  x_step);
    chk("att_eff",   "R10", att_eff,  x_eff);
  endtask

  // behavioural prediction of the next-cycle outputs from the current inputs
  task automatic predict();
    bit en, live, thr;
    int m;
    m = shape;
    en = m[3];
    live = (eg_phase >= 2);
    thr = (eg_att >= 512);
    x_clr = 0; x_pwe = 0; x_pwd = 0; x_awe = 0; x_awd = 0; x_evt = 0;
    x_eff = (en && ((m[2] ^ pol[0]) == 1) && live) ? ((512 - eg_att) & 1023) : eg_att;
    if (en && eg_phase != 4) x_step = thr ? 0 : step_in * 4;
    else                     x_step = step_in;
    if (!en) pol = 0;
    else if (tick && thr && live) begin
      x_evt = 1;
      if (m[0]) begin
        if (m[1]) pol = 1;
        if (((m[2] ^ pol[0]) == 0) && eg_phase != 4) begin x_awe = 1; x_awd = 1023; end
      end else begin
        if (m[1]) pol = 1 - pol; else x_clr = 1;
        if (eg_phase != 4) begin
          x_pwe = 1;
          if (rate_ks >= 94) begin
            x_awe = 1; x_awd = 0;
            x_pwd = (sus_lvl == 0) ? 2 : 3;
          end else x_pwd = 4;
        end
      end
    end else if (tick && thr && eg_phase == 1) begin
      x_awe = 1; x_awd = 1023; x_pwe = 1; x_pwd = 0;
    end
  endtask

  task automatic cyc(string s, int m, int ph, int a, int su, int r, int t, int st);
    @(negedge clk);
    if (have_x) compare();
    scen = s;
    shape = 4'(m); eg_phase = 3'(ph); eg_att = 10'(a); sus_lvl = 10'(su);
    rate_ks = 7'(r); tick = t[0]; step_in = 4'(st);
    predict();
    have_x = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("phase_clr", "R12", phase_clr, 0);
    chk("att_we", "R12", att_we, 0);
    chk("att_eff", "R12", att_eff, 0);
    chk("step_out", "R12", step_out, 0);
    rst = 1'b0;
    cyc("R1 disabled", 4'h7, 3, 600, 0, 50, 1, 3);
    cyc("R6 repeat", 4'h8, 3, 600, 0, 50, 1, 2);
    cyc("R7 fast sus", 4'h8, 2, 700, 0, 100, 1, 2);
    cyc("R7 fast dec", 4'h8, 3, 700, 40, 94, 1, 2);
    cyc("R7 slow", 4'h8, 3, 700, 40, 93, 1, 2);
    cyc("R7 in attack", 4'h8, 4, 700, 40, 50, 1, 2);
    cyc("R2 no tick", 4'h8, 3, 900, 0, 50, 0, 2);
    cyc("R2 below half", 4'h8, 3, 511, 0, 50, 1, 2);
    cyc("R4 hold", 4'h9, 2, 512, 0, 50, 1, 1);
    cyc("R4 hold inv", 4'hD, 2, 600, 0, 50, 1, 1);
    cyc("R3 hold alt 1", 4'hB, 3, 600, 0, 50, 1, 1);
    cyc("R3 hold alt 2", 4'hB, 3, 600, 0, 50, 1, 1);
    cyc("R3 view", 4'hB, 3, 100, 0, 50, 0, 1);
    cyc("R1 clear flag", 4'h0, 3, 100, 0, 50, 0, 1);
    cyc("R3 view after", 4'hB, 3, 100, 0, 50, 0, 1);
    for (int i = 0; i < 4; i++) begin
      cyc("R5 alt", 4'hA, 3, 800, 0, 50, 1, 1);
      cyc("R5 view", 4'hA, 2, 200, 0, 50, 0, 1);
    end
    cyc("R9 release", 4'h8, 1, 512, 0, 50, 1, 5);
    cyc("R9 release low", 4'h8, 1, 511, 0, 50, 1, 5);
    cyc("R8 step low", 4'h8, 2, 0, 0, 50, 0, 15);
    cyc("R8 step attack", 4'h8, 4, 900, 0, 50, 0, 15);
    cyc("R10 mirror", 4'hC, 3, 0, 0, 50, 0, 0);
    cyc("R10 mirror max", 4'hC, 2, 1023, 0, 50, 0, 0);
    for (int i = 0; i < 5000; i++) begin
      int ph, a;
      ph = $urandom_range(0, 4);
      a = ($urandom_range(0, 3) == 0) ? $urandom_range(500, 520) : $urandom_range(0, 1023);
      cyc("RND", $urandom_range(0, 15) | (($urandom_range(0, 3) != 0) ? 8 : 0), ph, a,
          ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 1023),
          $urandom_range(85, 127), ($urandom_range(0, 2) != 0) ? 1 : 0,
          $urandom_range(0, 15));
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule